// File: doc/BRIEF.md
# Packed Narrow and Interleave Unit

This block is the element-reshaping stage of a 64-bit packed SIMD datapath. It takes the second opcode byte of an instruction together with two 64-bit operands: a destination-side operand `dst_i` and a source-side operand `src_i`. It either narrows every element of both operands to half its width with clamping, or interleaves elements taken from the same half of the two operands. The result and an illegal-operation flag are registered and appear one clock after the inputs.

Three opcode bytes select narrowing. 0x6B turns signed 32-bit lanes into signed 16-bit lanes. 0x63 turns signed 16-bit lanes into signed 8-bit lanes. 0x67 turns signed 16-bit lanes into unsigned 8-bit lanes. Interleaving uses the opcode patterns 011000gg (lower halves) and 011010gg (upper halves). Here gg = 00 means 8-bit elements, 01 means 16-bit and 10 means 32-bit. The gg = 11 codes of those patterns are the 0x63 and 0x6B narrowing codes, because interleaving has no 64-bit form. Every other opcode byte is rejected.

Top module: `pkunit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result_o` becomes 0 and `illegal_o` becomes 0, whatever the other inputs are.
- R2: Opcode 0x6B clamps each signed 32-bit lane to a signed 16-bit value in the range -32768 to 32767. The two `dst_i` lanes fill result bits [31:0] and the two `src_i` lanes fill bits [63:32], each in ascending lane order.
- R3: Opcode 0x63 clamps each signed 16-bit lane to a signed 8-bit value in the range -128 to 127. The four `dst_i` lanes fill result bits [31:0] and the four `src_i` lanes fill bits [63:32], in order.
- R4: Opcode 0x67 treats each 16-bit lane as signed and clamps it to an unsigned 8-bit value. Negative lanes give 0x00 and lanes above 255 give 0xFF. The lane layout is the same as in R3.
- R5: Opcodes 0x60, 0x61 and 0x62 (8-, 16- and 32-bit elements) interleave the lower 32 bits of the two operands. Result element 2i is `dst_i` element i and element 2i+1 is `src_i` element i.
- R6: Opcodes 0x68, 0x69 and 0x6A interleave the upper 32 bits in the same way. Result element 2i is `dst_i` element H+i and element 2i+1 is `src_i` element H+i, where H is half the element count.
- R7: Only 0x60, 0x61, 0x62, 0x63, 0x67, 0x68, 0x69, 0x6A and 0x6B are accepted. Each of them drives `illegal_o` low, and every other byte value drives it high.
- R8: The result and the flag for inputs present at a rising edge appear on the outputs just after that edge, with no further delay.
- R9: When `illegal_o` is high, `result_o` is all zeros.
- R10: A lane whose value already fits the target type passes through unchanged, including the exact limits: 32767 and -32768 for 16-bit, 127 and -128 for signed 8-bit, and 0 and 255 for unsigned 8-bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode_i | input | 8 | Second opcode byte that selects the operation |
| dst_i | input | 64 | Destination-side operand |
| src_i | input | 64 | Source-side operand |
| result_o | output | 64 | Registered result |
| illegal_o | output | 1 | Registered illegal-opcode flag |

## Verification
The hardest cases to reach from the ports are lanes sitting exactly on, or one step past, a clamp limit. Examples are 0x0100 and 0xFF7F for the byte targets, and 0x00008000 or 0xFFFF7FFF for the word target. Uniform random operands almost never produce them. The stimulus therefore builds every operand lane by lane from a table of limit-adjacent values mixed with random ones, so each lane position of each operand meets saturation, pass-through and sign-flip cases. A sweep over all 256 opcode bytes covers the boundary between the accepted codes and the rejected neighbours.

// File: rtl/pku_pkg.sv
package pku_pkg;
  localparam int WORD_BITS = 64;
  localparam int NUM_SEL   = 5;

  // one-hot selection indices
  localparam int SEL_NDW = 0;   // signed 32 -> signed 16
  localparam int SEL_NSB = 1;   // signed 16 -> signed 8
  localparam int SEL_NUB = 2;   // signed 16 -> unsigned 8
  localparam int SEL_ILO = 3;   // interleave lower halves
  localparam int SEL_IHI = 4;   // interleave upper halves

  localparam logic [7:0] CODE_NDW = 8'h6B;
  localparam logic [7:0] CODE_NSB = 8'h63;
  localparam logic [7:0] CODE_NUB = 8'h67;
  localparam logic [5:0] PFX_ILO  = 6'b011000;
  localparam logic [5:0] PFX_IHI  = 6'b011010;

  typedef logic [NUM_SEL-1:0] pk_sel_t;
  typedef logic [1:0]         pk_gran_t;
endpackage

// File: rtl/pku_decode.sv
module pku_decode
  import pku_pkg::*;
(
  input  logic [7:0] opcode_i,
  output pk_sel_t    sel_o,
  output pk_gran_t   gran_o,
  output logic       illegal_o
);
  logic gran_ok;

  assign gran_o  = opcode_i[1:0];
  assign gran_ok = (opcode_i[1:0] != 2'b11);

  always_comb begin
    sel_o = '0;
    if (opcode_i == CODE_NDW)                       sel_o[SEL_NDW] = 1'b1;
    else if (opcode_i == CODE_NSB)                  sel_o[SEL_NSB] = 1'b1;
    else if (opcode_i == CODE_NUB)                  sel_o[SEL_NUB] = 1'b1;
    else if (opcode_i[7:2] == PFX_ILO && gran_ok)   sel_o[SEL_ILO] = 1'b1;
    else if (opcode_i[7:2] == PFX_IHI && gran_ok)   sel_o[SEL_IHI] = 1'b1;
  end

  assign illegal_o = (sel_o == '0);
endmodule

// File: rtl/pku_narrow.sv
module pku_narrow #(
  parameter int DATA_W       = 64,
  parameter int IN_W         = 32,
  parameter int OUT_W        = 16,
  parameter bit UNSIGNED_OUT = 1'b0
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int LANES = DATA_W / IN_W;

  function automatic logic [OUT_W-1:0] clamp_s(input logic [IN_W-1:0] x);
    logic [IN_W-OUT_W:0] top;
    top = x[IN_W-1:OUT_W-1];
    if (top == '0 || top == '1) return x[OUT_W-1:0];
    else if (x[IN_W-1])         return {1'b1, {(OUT_W-1){1'b0}}};
    else                        return {1'b0, {(OUT_W-1){1'b1}}};
  endfunction

  function automatic logic [OUT_W-1:0] clamp_u(input logic [IN_W-1:0] x);
    if (x[IN_W-1])                  return '0;
    else if (|x[IN_W-2:OUT_W])      return '1;
    else                            return x[OUT_W-1:0];
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (UNSIGNED_OUT) begin : g_u
      assign res_o[i*OUT_W +: OUT_W]         = clamp_u(dst_i[i*IN_W +: IN_W]);
      assign res_o[(LANES+i)*OUT_W +: OUT_W] = clamp_u(src_i[i*IN_W +: IN_W]);
    end else begin : g_s
      assign res_o[i*OUT_W +: OUT_W]         = clamp_s(dst_i[i*IN_W +: IN_W]);
      assign res_o[(LANES+i)*OUT_W +: OUT_W] = clamp_s(src_i[i*IN_W +: IN_W]);
    end
  end
endmodule

// File: rtl/pku_interleave.sv
module pku_interleave #(
  parameter int DATA_W = 64,
  parameter int ELEM_W = 8
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o
);
  localparam int ELEMS = DATA_W / ELEM_W;
  localparam int HALF  = ELEMS / 2;

  for (genvar i = 0; i < HALF; i++) begin : g_pair
    assign lo_o[(2*i)*ELEM_W   +: ELEM_W] = dst_i[i*ELEM_W +: ELEM_W];
    assign lo_o[(2*i+1)*ELEM_W +: ELEM_W] = src_i[i*ELEM_W +: ELEM_W];
    assign hi_o[(2*i)*ELEM_W   +: ELEM_W] = dst_i[(HALF+i)*ELEM_W +: ELEM_W];
    assign hi_o[(2*i+1)*ELEM_W +: ELEM_W] = src_i[(HALF+i)*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/pkunit.sv
module pkunit
  import pku_pkg::*;
#(
  parameter int DATA_W = WORD_BITS,
  parameter int GRANS  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        opcode_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  pk_sel_t  sel;
  pk_gran_t gran;
  logic     bad_op;

  logic [DATA_W-1:0] n_dw, n_sb, n_ub;
  logic [DATA_W-1:0] il_lo [GRANS];
  logic [DATA_W-1:0] il_hi [GRANS];
  logic [DATA_W-1:0] pick_lo, pick_hi, nxt;

  pku_decode u_dec (
    .opcode_i (opcode_i),
    .sel_o    (sel),
    .gran_o   (gran),
    .illegal_o(bad_op)
  );

  pku_narrow #(.DATA_W(DATA_W), .IN_W(32), .OUT_W(16), .UNSIGNED_OUT(1'b0)) u_ndw (
    .dst_i(dst_i), .src_i(src_i), .res_o(n_dw));
  pku_narrow #(.DATA_W(DATA_W), .IN_W(16), .OUT_W(8),  .UNSIGNED_OUT(1'b0)) u_nsb (
    .dst_i(dst_i), .src_i(src_i), .res_o(n_sb));
  pku_narrow #(.DATA_W(DATA_W), .IN_W(16), .OUT_W(8),  .UNSIGNED_OUT(1'b1)) u_nub (
    .dst_i(dst_i), .src_i(src_i), .res_o(n_ub));

  for (genvar g = 0; g < GRANS; g++) begin : g_il
    pku_interleave #(.DATA_W(DATA_W), .ELEM_W(8 << g)) u_il (
      .dst_i(dst_i), .src_i(src_i), .lo_o(il_lo[g]), .hi_o(il_hi[g]));
  end

  always_comb begin
    case (gran)
      2'd0:    begin pick_lo = il_lo[0]; pick_hi = il_hi[0]; end
      2'd1:    begin pick_lo = il_lo[1]; pick_hi = il_hi[1]; end
      2'd2:    begin pick_lo = il_lo[2]; pick_hi = il_hi[2]; end
      default: begin pick_lo = '0;       pick_hi = '0;       end
    endcase
  end

  always_comb begin
    nxt = '0;
    if (sel[SEL_NDW])      nxt = n_dw;
    else if (sel[SEL_NSB]) nxt = n_sb;
    else if (sel[SEL_NUB]) nxt = n_ub;
    else if (sel[SEL_ILO]) nxt = pick_lo;
    else if (sel[SEL_IHI]) nxt = pick_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      result_o  <= nxt;
      illegal_o <= bad_op;
    end
  end

  // R1: reset clears both outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (result_o == '0 && !illegal_o));

  // R7: at most one operation is selected at a time
  a_r7_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));

  // R9: a flagged opcode never leaves data on the result
  a_r9_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> result_o == '0);

  // R4: negative 16-bit lane gives an unsigned byte of zero
  a_r4_neg_to_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel[SEL_NUB]) && $past(dst_i[15])) |-> result_o[7:0] == 8'h00);

  // R3: large positive 16-bit lane clamps to +127
  a_r3_pos_clamp: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel[SEL_NSB]) && ($past(signed'(dst_i[15:0])) > 16'sd127))
      |-> result_o[7:0] == 8'h7F);

  // R5: low interleave places the destination byte first
  a_r5_dst_first: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel[SEL_ILO]) && $past(gran) == 2'd0)
      |-> result_o[7:0] == $past(dst_i[7:0]));
endmodule

// File: tb/sim_pkunit.sv
`timescale 1ns/1ps
module sim_pkunit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  opcode_i = 8'h00;
  logic [63:0] dst_i = '0, src_i = '0;
  logic [63:0] result_o;
  logic        illegal_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic        ill;
    string       tag;
    logic [7:0]  op;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  pkunit u0 (
    .clk(clk), .rst(rst), .opcode_i(opcode_i),
    .dst_i(dst_i), .src_i(src_i),
    .result_o(result_o), .illegal_o(illegal_o)
  );

  function automatic longint lane(input logic [63:0] x, input int idx, input int w);
    logic [63:0] m;
    m = (w == 64) ? '1 : ((64'h1 << w) - 64'h1);
    return longint'((x >> (idx * w)) & m);
  endfunction

  function automatic logic [63:0] ref_narrow(input logic [63:0] d, input logic [63:0] s,
                                            input int iw, input int ow, input bit uns);
    logic [63:0] r;
    longint lim_lo, lim_hi, v;
    int n;
    r = '0;
    n = 64 / iw;
    if (uns) begin lim_lo = 0; lim_hi = (longint'(1) << ow) - 1; end
    else begin lim_lo = -(longint'(1) << (ow - 1)); lim_hi = (longint'(1) << (ow - 1)) - 1; end
    for (int k = 0; k < 2 * n; k++) begin
      v = lane((k < n) ? d : s, k % n, iw);
      if (v >= (longint'(1) << (iw - 1))) v = v - (longint'(1) << iw);
      if (v < lim_lo) v = lim_lo;
      if (v > lim_hi) v = lim_hi;
      r = r | ((64'(v) & ((64'h1 << ow) - 64'h1)) << (k * ow));
    end
    return r;
  endfunction

  function automatic logic [63:0] ref_spread(input logic [63:0] d, input logic [63:0] s,
                                            input int g, input bit upper);
    logic [63:0] r;
    int e, h, base;
    r = '0;
    e = 8 << g;
    h = (64 / e) / 2;
    base = upper ? h : 0;
    for (int i = 0; i < h; i++) begin
      r = r | (64'(lane(d, base + i, e)) << ((2 * i) * e));
      r = r | (64'(lane(s, base + i, e)) << ((2 * i + 1) * e));
    end
    return r;
  endfunction

  task automatic model(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                       output logic [63:0] r, output logic ill, output string tag);
    ill = 1'b0;
    r   = '0;
    if (op == 8'h6B)      begin r = ref_narrow(d, s, 32, 16, 1'b0); tag = "R2"; end
    else if (op == 8'h63) begin r = ref_narrow(d, s, 16, 8, 1'b0);  tag = "R3"; end
    else if (op == 8'h67) begin r = ref_narrow(d, s, 16, 8, 1'b1);  tag = "R4"; end
    else if (op >= 8'h60 && op <= 8'h62) begin r = ref_spread(d, s, int'(op[1:0]), 1'b0); tag = "R5"; end
    else if (op >= 8'h68 && op <= 8'h6A) begin r = ref_spread(d, s, int'(op[1:0]), 1'b1); tag = "R6"; end
    else begin ill = 1'b1; tag = "R7 R9"; end
  endtask

  // driver: apply one operation and queue its expected outcome
  task automatic send(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                      input string extra);
    exp_t e;
    @(negedge clk);
    opcode_i = op; dst_i = d; src_i = s;
    model(op, d, s, e.res, e.ill, e.tag);
    if (extra != "") e.tag = {e.tag, " ", extra};
    e.op = op;
    sb_q.push_back(e);
  endtask

  // monitor: outputs must reflect the inputs of the preceding edge (R8)
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_tests++;
      if (result_o !== e.res || illegal_o !== e.ill) begin
        n_fail++;
        $display("FAIL %s R8 op=%02h actual res=%016h ill=%0b expected res=%016h ill=%0b",
                 e.tag, e.op, result_o, illegal_o, e.res, e.ill);
      end
    end
  end

  function automatic logic [15:0] wcorner();
    case ($urandom % 12)
      0: return 16'h7FFF;  1: return 16'h8000;  2: return 16'h007F;
      3: return 16'h0080;  4: return 16'hFF80;  5: return 16'hFF7F;
      6: return 16'h00FF;  7: return 16'h0100;  8: return 16'hFFFF;
      9: return 16'h0000;  default: return 16'($urandom);
    endcase
  endfunction

  function automatic logic [31:0] dcorner();
    case ($urandom % 10)
      0: return 32'h0000_7FFF;  1: return 32'h0000_8000;  2: return 32'hFFFF_8000;
      3: return 32'hFFFF_7FFF;  4: return 32'h7FFF_FFFF;  5: return 32'h8000_0000;
      6: return 32'h0000_0000;  7: return 32'hFFFF_FFFF;  default: return $urandom;
    endcase
  endfunction

  function automatic logic [63:0] mk_w();
    return {wcorner(), wcorner(), wcorner(), wcorner()};
  endfunction

  function automatic logic [63:0] mk_d();
    return {dcorner(), dcorner()};
  endfunction

  task automatic check_reset(input string what);
    @(negedge clk);
    n_tests++;
    if (result_o !== 64'h0 || illegal_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 %s actual res=%016h ill=%0b expected res=0000000000000000 ill=0",
               what, result_o, illegal_o);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [9];
    ops = '{8'h60, 8'h61, 8'h62, 8'h63, 8'h67, 8'h68, 8'h69, 8'h6A, 8'h6B};

    // R1: reset with live, legal and illegal inputs
    rst = 1'b1; opcode_i = 8'h6B; dst_i = 64'h1234_5678_9ABC_DEF0; src_i = '1;
    repeat (2) @(posedge clk);
    check_reset("start, legal op");
    opcode_i = 8'hFF;
    check_reset("start, bad op");
    @(negedge clk); rst = 1'b0;

    // R10: exact limits pass through unchanged
    send(8'h6B, 64'hFFFF_8000_0000_7FFF, 64'h0000_0000_FFFF_FFFF, "R10");
    send(8'h63, 64'hFF80_007F_0000_FFFF, 64'h0001_FF80_007F_FFFE, "R10");
    send(8'h67, 64'h00FF_0000_0001_00FE, 64'h0000_00FF_0080_007F, "R10");
    // one step past each limit
    send(8'h6B, 64'hFFFF_7FFF_0000_8000, 64'h8000_0000_7FFF_FFFF, "");
    send(8'h63, 64'hFF7F_0080_8000_7FFF, 64'h0100_FEFF_FF7F_0080, "");
    send(8'h67, 64'h0100_FFFF_8000_7FFF, 64'hFF00_0100_00FF_FFFF, "");
    // interleave patterns with distinct lane markers
    for (int g = 0; g < 3; g++) begin
      send(8'h60 + 8'(g), 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, "");
      send(8'h68 + 8'(g), 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110, "");
    end

    // saturation-focused random stimulus
    for (int n = 0; n < 150; n++) begin
      send(8'h6B, mk_d(), mk_d(), "");
      send(8'h63, mk_w(), mk_w(), "");
      send(8'h67, mk_w(), mk_w(), "");
      send(ops[$urandom % 9], {$urandom, $urandom}, {$urandom, $urandom}, "");
    end

    // R7: every opcode byte
    for (int op = 0; op < 256; op++)
      send(8'(op), {$urandom, $urandom}, {$urandom, $urandom}, "");

    // back-to-back illegal then legal, R9 then flag drop
    send(8'hFF, '1, '1, "");
    send(8'h61, '1, 64'h0, "");

    // mid-run reset
    @(negedge clk);
    wait (sb_q.size() == 0);
    @(negedge clk);
    rst = 1'b1; opcode_i = 8'h62; dst_i = '1; src_i = '1;
    @(posedge clk);
    check_reset("mid-run");
    @(negedge clk); rst = 1'b0;
    send(8'h6A, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, "");
    repeat (3) @(posedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule